// File: doc/BRIEF.md
# Parcel-Stream Block Output Transmitter

This block sends a block of 64-bit words to an external device over a synchronous channel. It splits each word into four 16-bit parcels. The least significant parcel goes first. Each parcel is marked valid by a Ready pulse of fixed width. The first parcel of a block goes out alone. The transmitter then waits for a Resume pulse from the device. After Resume it streams three more parcels to finish the first word, then four parcels for each word that remains. A Disconnect pulse is sent with the first parcel of the final word, and it marks the end of the transfer.

Words come from a source through a valid/ready handshake, one word at a time. When the source stalls, the parcel stream pauses with Ready low until a word is available. The downstream storage device accepts only blocks of 1 word or 512 words. A start command with any other length is refused, raises a length-error flag and sends nothing. A master-clear command aborts any transfer in progress and sends a Master Clear pulse to the device.

The controller is a five-state machine:
- IDLE waits for a start command. A start with a legal length moves to FETCH.
- FETCH holds the word-ready output high. When a word is taken it moves to PULSE.
- PULSE drives Ready for the pulse width. When the pulse ends there are three exits:
  - to WAIT_RES after the first parcel of a block;
  - to IDLE after the last parcel of the last word;
  - to GAP in every other case.
- GAP is one low cycle. It moves to PULSE for the next parcel of the same word, or to FETCH after the fourth parcel.
- WAIT_RES waits for a Resume rising edge, then moves to GAP.

A master-clear command takes every state to IDLE.

Top module: `parcel_tx`

## Requirements
- R1: After reset, ready_out, disc_out, mclr_out, busy, word_ready, len_err and proto_err are all low, and parcel_out is zero.
- R2: A start in IDLE is accepted only when blk_len is 1 or 512. Any other length sets len_err, sends no Ready pulse and leaves busy low. len_err stays set until the next accepted start or a master clear.
- R3: Every Ready pulse is high for exactly PULSE_CYCLES clock cycles. At least one low cycle separates two consecutive pulses.
- R4: Parcel k of a word carries word bits [16k+15:16k]. Parcels go out in the order k = 0, 1, 2, 3 and words in source order. parcel_out shows the parcel while ready_out is high and is zero while ready_out is low.
- R5: After the first Ready pulse of a block, no further Ready pulse starts until a rising edge of resume_in has been seen. The remaining 4N-1 parcels of an N-word block then follow with no further handshake.
- R6: disc_out is high exactly during the Ready pulse of parcel 0 of the last word. In a 1-word block this is the first, handshaked parcel.
- R7: A word is taken when word_valid and word_ready are both high at a clock edge. While word_ready is high, ready_out is low.
- R8: busy rises in the cycle after an accepted start. It is high whenever ready_out is high, and it falls in the same cycle as the last parcel's Ready pulse.
- R9: A rising edge of resume_in seen outside WAIT_RES has no effect on the outputs, except that it sets proto_err. proto_err stays set until a master clear.
- R10: A master-clear command forces IDLE (busy and ready_out low the next cycle) and clears both error flags. From the next cycle it drives mclr_out high for exactly PULSE_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a block transfer (sampled in IDLE) |
| blk_len | input | LEN_W | Block length in words |
| word_data | input | WORD_W | Word from the source |
| word_valid | input | 1 | Source has a word |
| word_ready | output | 1 | Transmitter takes a word this cycle |
| resume_in | input | 1 | Resume pulse from the device |
| mclr_cmd | input | 1 | Master-clear command |
| parcel_out | output | PARCEL_W | Parcel bus to the device |
| ready_out | output | 1 | Ready pulse, parcel valid |
| disc_out | output | 1 | Disconnect pulse |
| mclr_out | output | 1 | Master Clear pulse to the device |
| busy | output | 1 | Transfer in progress |
| len_err | output | 1 | Sticky illegal-length flag |
| proto_err | output | 1 | Sticky unexpected-Resume flag |

## Verification
The block is exercised with four kinds of transfer:
- A 1-word block, with and without source stalls. Here Disconnect must ride on the handshaked parcel and only three parcels follow Resume.
- A 512-word block with periodic stalls. This separates correct group-of-four streaming and word ordering from a design that drops or repeats parcels across word boundaries.
- Illegal lengths (0, 5, 513) and a stray Resume in IDLE. These show that refused commands emit nothing and only raise their flags.
- A master clear in the middle of a 512-word block. This shows the abort, the Master Clear pulse width and the clearing of the flags, and that a new block then runs normally.

// File: rtl/parcel_tx_pkg.sv
package parcel_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PULSE,
        ST_GAP,
        ST_WAIT_RES
    } tx_state_e;
endpackage

// File: rtl/parcel_tx_edge.sv
module parcel_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_out
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise_out = sig_in & ~sig_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_out |=> !rise_out); // R9
endmodule

// File: rtl/parcel_tx_mux.sv
module parcel_tx_mux #(
    parameter int WORD_W   = 64,
    parameter int PARCEL_W = 16,
    localparam int NUM     = WORD_W / PARCEL_W,
    localparam int SEL_W   = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [WORD_W-1:0]   word_in,
    input  logic [SEL_W-1:0]    sel,
    input  logic                enable,
    output logic [PARCEL_W-1:0] parcel_out
);
    logic [PARCEL_W-1:0] lane [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_lane
        assign lane[g] = word_in[g*PARCEL_W +: PARCEL_W];
    end

    assign parcel_out = enable ? lane[sel] : '0;
endmodule

// File: rtl/parcel_tx_mclr.sv
module parcel_tx_mclr #(
    parameter int PULSE_CYCLES = 4,
    localparam int CW = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse_out
);
    logic [CW-1:0] left_q;
    logic [CW:0]   run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            left_q <= '0;
        else if (trigger)      left_q <= CW'(PULSE_CYCLES);
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign pulse_out = (left_q != '0);

    // Run length of the pulse, for the width check below.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (pulse_out) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    AST_MCLR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> pulse_out); // R10
    AST_MCLR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> (run_q >= (CW+1)'(PULSE_CYCLES))); // R10
endmodule

// File: rtl/parcel_tx.sv
module parcel_tx
    import parcel_tx_pkg::*;
#(
    parameter int WORD_W       = 64,
    parameter int PARCEL_W     = 16,
    parameter int PULSE_CYCLES = 4,
    parameter int LEN_W        = 10,
    parameter int SHORT_BLOCK  = 1,
    parameter int LONG_BLOCK   = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LEN_W-1:0]    blk_len,
    input  logic [WORD_W-1:0]   word_data,
    input  logic                word_valid,
    output logic                word_ready,
    input  logic                resume_in,
    input  logic                mclr_cmd,
    output logic [PARCEL_W-1:0] parcel_out,
    output logic                ready_out,
    output logic                disc_out,
    output logic                mclr_out,
    output logic                busy,
    output logic                len_err,
    output logic                proto_err
);
    localparam int NUM_PARCELS = WORD_W / PARCEL_W;
    localparam int IDX_W       = (NUM_PARCELS > 1) ? $clog2(NUM_PARCELS) : 1;
    localparam int CNT_W       = $clog2(PULSE_CYCLES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PARCELS - 1);
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYCLES - 1);

    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  words_left_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              first_q;
    logic              len_err_q, proto_err_q;
    logic              res_rise;
    logic              len_ok, pulse_done, last_parcel;

    assign len_ok      = (blk_len == LEN_W'(SHORT_BLOCK)) || (blk_len == LEN_W'(LONG_BLOCK));
    assign pulse_done  = (cnt_q == PULSE_END);
    assign last_parcel = (idx_q == LAST_IDX) && (words_left_q == LEN_W'(1));

    parcel_tx_edge u_res_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (resume_in),
        .rise_out (res_rise)
    );

    parcel_tx_mclr #(.PULSE_CYCLES(PULSE_CYCLES)) u_mclr (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger   (mclr_cmd),
        .pulse_out (mclr_out)
    );

    parcel_tx_mux #(.WORD_W(WORD_W), .PARCEL_W(PARCEL_W)) u_mux (
        .word_in    (word_q),
        .sel        (idx_q),
        .enable     (ready_out),
        .parcel_out (parcel_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start && len_ok) state_d = ST_FETCH;
            ST_FETCH:    if (word_valid) state_d = ST_PULSE;
            ST_PULSE:    if (pulse_done) begin
                             if (first_q)          state_d = ST_WAIT_RES;
                             else if (last_parcel) state_d = ST_IDLE;
                             else                  state_d = ST_GAP;
                         end
            ST_GAP:      state_d = (idx_q == LAST_IDX) ? ST_FETCH : ST_PULSE;
            ST_WAIT_RES: if (res_rise) state_d = ST_GAP;
            default:     state_d = ST_IDLE;
        endcase
        if (mclr_cmd) state_d = ST_IDLE;
    end

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q       <= '0;
            idx_q        <= '0;
            words_left_q <= '0;
            cnt_q        <= '0;
            first_q      <= 1'b0;
            len_err_q    <= 1'b0;
            proto_err_q  <= 1'b0;
        end else if (mclr_cmd) begin
            idx_q        <= '0;
            words_left_q <= '0;
            cnt_q        <= '0;
            first_q      <= 1'b0;
            len_err_q    <= 1'b0;
            proto_err_q  <= 1'b0;
        end else begin
            if (res_rise && state_q != ST_WAIT_RES) proto_err_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    if (len_ok) begin
                        words_left_q <= blk_len;
                        idx_q        <= '0;
                        first_q      <= 1'b1;
                        len_err_q    <= 1'b0;
                    end else begin
                        len_err_q    <= 1'b1;
                    end
                end
                ST_FETCH: if (word_valid) begin
                    word_q <= word_data;
                    cnt_q  <= '0;
                end
                ST_PULSE: cnt_q <= cnt_q + 1'b1;
                ST_GAP: begin
                    cnt_q <= '0;
                    if (idx_q == LAST_IDX) begin
                        idx_q        <= '0;
                        words_left_q <= words_left_q - 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_WAIT_RES: if (res_rise) first_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ready_out  = (state_q == ST_PULSE);
        word_ready = (state_q == ST_FETCH);
        busy       = (state_q != ST_IDLE);
        disc_out   = ready_out && (idx_q == '0) && (words_left_q == LEN_W'(1));
        len_err    = len_err_q;
        proto_err  = proto_err_q;
    end

    // Ready run length, used by the width check.
    logic [CNT_W:0] hi_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_len_q <= '0;
        else if (ready_out) hi_len_q <= hi_len_q + 1'b1;
        else                hi_len_q <= '0;
    end

    AST_READY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready_out) && !$past(mclr_cmd)) |-> (hi_len_q == (CNT_W+1)'(PULSE_CYCLES))); // R3
    AST_DISC_IN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        disc_out |-> ready_out); // R6
    AST_NO_SEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ready_out); // R8
    AST_BAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !len_ok && !mclr_cmd) |=> (len_err && !busy)); // R2
    AST_STRAY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rise && state_q != ST_WAIT_RES && !mclr_cmd) |=> proto_err); // R9
    AST_MCLR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_cmd |=> (!busy && !len_err && !proto_err)); // R10
endmodule

// File: tb/parcel_tx_test.sv
`timescale 1ns/1ps
module parcel_tx_test;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  blk_len = '0;
    logic [63:0] word_data = '0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic        resume_in = 1'b0;
    logic        mclr_cmd = 1'b0;
    logic [15:0] parcel_out;
    logic        ready_out, disc_out, mclr_out, busy, len_err, proto_err;

    parcel_tx #(.PULSE_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
        .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
        .resume_in(resume_in), .mclr_cmd(mclr_cmd), .parcel_out(parcel_out),
        .ready_out(ready_out), .disc_out(disc_out), .mclr_out(mclr_out),
        .busy(busy), .len_err(len_err), .proto_err(proto_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference model state
    logic [63:0] src_words[$];
    logic [15:0] exp_par[$];
    bit  hs = 0;
    bit  stall_en = 0;
    int  blk_words = 0;
    int  total = 0;
    int  rcv_cnt = 0;
    bit  block_done = 0;
    bit  waiting_resume = 0;
    int  res_wait = 0;
    int  res_hold = 0;
    bit  abort_mode = 0;
    bit  prev_ready = 0;
    int  hi_cnt = 0;
    int  lo_cnt = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Word source
    always @(negedge clk) begin
        if (hs && src_words.size() > 0) void'(src_words.pop_front());
        word_valid = (src_words.size() > 0) && !(stall_en && (cyc % 3 == 1));
        word_data  = (src_words.size() > 0) ? src_words[0] : 64'h0;
        hs = word_valid && word_ready;
    end

    // Device model and per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_ready)
                chk(!ready_out, "R7", "ready while fetching", ready_out, 0);
            if (ready_out) begin
                chk(busy, "R8", "busy during ready", busy, 1);
                if (!prev_ready) begin
                    chk(lo_cnt >= 1, "R3", "low gap", lo_cnt, 1);
                    chk(!waiting_resume, "R5", "ready before resume", 1, 0);
                    if (exp_par.size() == 0) begin
                        chk(0, "R4", "unexpected parcel", parcel_out, 0);
                    end else begin
                        chk(parcel_out == exp_par[0], "R4", "parcel value", parcel_out, exp_par[0]);
                        void'(exp_par.pop_front());
                    end
                    chk(disc_out == (rcv_cnt == 4*(blk_words-1)), "R6", "disconnect",
                        disc_out, (rcv_cnt == 4*(blk_words-1)));
                    rcv_cnt++;
                end
                hi_cnt++;
                lo_cnt = 0;
            end else begin
                if (prev_ready) begin
                    if (!abort_mode) begin
                        chk(hi_cnt == P, "R3", "ready width", hi_cnt, P);
                        chk(parcel_out == 16'h0, "R4", "bus idle value", parcel_out, 0);
                        chk(!disc_out, "R6", "disconnect after pulse", disc_out, 0);
                        if (rcv_cnt == 1) begin
                            waiting_resume = 1;
                            res_wait = 6;
                        end
                        if (rcv_cnt == total) begin
                            chk(!busy, "R8", "busy after last pulse", busy, 0);
                            block_done = 1;
                        end
                    end
                end
                hi_cnt = 0;
                lo_cnt++;
            end
            prev_ready = ready_out;
            if (waiting_resume) begin
                if (res_wait == 0) begin
                    res_hold = 3;
                    waiting_resume = 0;
                end else res_wait--;
            end
            if (res_hold > 0) begin
                resume_in = 1'b1;
                res_hold--;
            end else resume_in = 1'b0;
        end
    end

    task automatic begin_block(input int n, input bit stall);
        stall_en   = stall;
        blk_words  = n;
        total      = 4*n;
        rcv_cnt    = 0;
        block_done = 0;
        for (int i = 0; i < n; i++) begin
            logic [63:0] w;
            w = 64'h0123_4567_89AB_CDEF ^ (64'(i + n) * 64'h9E37_79B9_7F4A_7C15);
            src_words.push_back(w);
            for (int k = 0; k < 4; k++) exp_par.push_back(w[16*k +: 16]);
        end
        @(negedge clk);
        blk_len = 10'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R8", "busy after start", busy, 1);
        chk(!len_err, "R2", "len_err on legal start", len_err, 0);
    endtask

    task automatic run_block(input int n, input bit stall);
        begin_block(n, stall);
        while (!block_done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_par.size() == 0, "R4", "parcels left", exp_par.size(), 0);
        chk(src_words.size() == 0, "R7", "words left", src_words.size(), 0);
        chk(!busy, "R8", "idle after block", busy, 0);
    endtask

    task automatic bad_len(input int n);
        @(negedge clk);
        blk_len = 10'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(len_err, "R2", "len_err set", len_err, 1);
        chk(!busy, "R2", "busy on refused start", busy, 0);
        repeat (10) @(negedge clk);
        chk(!word_ready && !ready_out, "R2", "nothing sent", ready_out, 0);
        chk(len_err, "R2", "len_err sticky", len_err, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!ready_out && !disc_out && !mclr_out && !busy && !word_ready,
            "R1", "outputs in reset", {ready_out, disc_out, mclr_out, busy, word_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!len_err && !proto_err && parcel_out == 16'h0, "R1", "flags after reset",
            {len_err, proto_err}, 0);

        run_block(1, 0);   // R5 R6: single word, disconnect on handshaked parcel
        run_block(1, 1);   // R7 stall
        bad_len(5);
        bad_len(0);
        bad_len(513);
        run_block(1, 0);
        chk(!len_err, "R2", "len_err cleared by legal start", len_err, 0);
        run_block(512, 1); // long block with stalls
        chk(!proto_err, "R9", "no protocol error in normal flow", proto_err, 0);

        // R9: stray Resume in IDLE
        @(negedge clk); #1 res_hold = 2;
        repeat (5) @(negedge clk);
        chk(proto_err, "R9", "proto_err set", proto_err, 1);
        chk(!busy && !ready_out, "R9", "stray resume no effect", busy, 0);
        repeat (5) @(negedge clk);
        chk(proto_err, "R9", "proto_err sticky", proto_err, 1);

        // R10: abort in the middle of a long block
        begin_block(512, 0);
        while (rcv_cnt < 10) @(negedge clk);
        abort_mode = 1;
        mclr_cmd = 1'b1;
        @(negedge clk);
        mclr_cmd = 1'b0;
        chk(!busy && !ready_out, "R10", "abort to idle", busy, 0);
        chk(!proto_err && !len_err, "R10", "flags cleared", proto_err, 0);
        chk(mclr_out, "R10", "mclr cycle 1", mclr_out, 1);
        for (int i = 2; i <= P; i++) begin
            @(negedge clk);
            chk(mclr_out, "R10", "mclr held", mclr_out, 1);
        end
        @(negedge clk);
        chk(!mclr_out, "R10", "mclr ended", mclr_out, 0);
        #1;
        src_words.delete();
        exp_par.delete();
        hs = 0;
        waiting_resume = 0;
        res_hold = 0;
        @(negedge clk);
        abort_mode = 0;
        run_block(1, 0);   // clean block after abort

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule